// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Line-Break Detection

This block takes one asynchronous serial line and turns it into characters. A one-cycle enable arrives sixteen times per bit period and paces all bit timing. Static configuration inputs pick a 7- or 8-bit character, whether a parity bit follows the data, whether that parity is odd or even, and whether the frame ends with one or two stop bits. The configuration must not change while a character is being received.

Each finished character goes into a 16-entry receive queue. An entry holds the data byte and two flags, one for a bad stop bit and one for a parity mismatch. The consumer sees the oldest entry on the read port and removes it with a one-cycle pop. A fill count gives the number of stored entries. A sticky overrun flag records any character that was lost because the queue was full.

A line that stays low after a framing error raises a sticky break flag once the low has lasted longer than a whole frame. While the line stays low after that error, no new character is started.

Top module: `serrx_top`

## Requirements
- R1: After reset, the queue is empty (`rd_valid`=0, `fill_cnt`=0), and `ovr_flag` and `brk_flag` are 0.
- R2: A start bit is accepted only if the line is still low at the 8th tick after the falling edge is seen. A shorter low pulse is dropped and writes nothing to the queue.
- R3: Data bits are received least significant bit first. With `cfg_7bit`=1, seven bits are taken and `rd_data[7]` reads 0. With `cfg_7bit`=0, eight bits are taken.
- R4: With `cfg_par_en`=1, one parity bit follows the data. `rd_pe`=1 when the data bits plus the parity bit hold an odd count of ones and `cfg_par_odd`=0 (even sense), or an even count of ones and `cfg_par_odd`=1. With `cfg_par_en`=0, `rd_pe` is 0.
- R5: `cfg_stop2`=1 selects two stop bits. `rd_fe`=1 when any stop bit is sampled low. The character is still stored.
- R6: The queue returns characters in arrival order. The head entry is visible without a pop. A pop on an empty queue has no effect.
- R7: `fill_cnt` equals the number of stored entries, from 0 to 16.
- R8: A character that completes while the queue holds 16 entries is dropped and sets `ovr_flag`. The flag stays set until `clr_ovr`. A new overrun in the same cycle as `clr_ovr` wins.
- R9: After a character with a framing error, if the line stays low for more than (1 + data bits + parity bit + stop bits) × 16 ticks, counted from the failing stop sample, `brk_flag` is set. It stays set until `clr_brk`.
- R10: After a character with a framing error, while the line stays low, no further character is started or stored. Reception resumes once the line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit period |
| rxd | input | 1 | Serial line, idle high |
| cfg_7bit | input | 1 | 1: 7 data bits, 0: 8 data bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_stop2 | input | 1 | 1: two stop bits |
| pop | input | 1 | Remove head entry |
| clr_ovr | input | 1 | Clear overrun flag |
| clr_brk | input | 1 | Clear break flag |
| rd_data | output | 8 | Head entry data |
| rd_fe | output | 1 | Head entry framing error |
| rd_pe | output | 1 | Head entry parity error |
| rd_valid | output | 1 | Queue not empty |
| fill_cnt | output | 5 | Number of stored entries |
| ovr_flag | output | 1 | Sticky overrun |
| brk_flag | output | 1 | Sticky break |

## Verification
Two events can land in the same cycle: setting the overrun flag and clearing it. The bench fills the queue to sixteen entries, holds `clr_ovr` high, and sends a seventeenth character. The flag must still be seen high for the cycle after the drop, because a new overrun beats the clear. A second overflow sent without the clear must then leave the flag standing. On the break side, one long low that begins inside a frame must produce exactly one framing-error entry and the break flag. No garbage characters may be stored behind that entry.

// File: rtl/serrx_pkg.sv
package serrx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } rx_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       fe;
    logic       pe;
  } rx_item_t;

  localparam int unsigned ITEM_W = $bits(rx_item_t);
endpackage

// File: rtl/serrx_frame.sv
module serrx_frame
  import serrx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     rx,
  input  logic     cfg_7bit,
  input  logic     cfg_par_en,
  input  logic     cfg_par_odd,
  input  logic     cfg_stop2,
  input  logic     hold,
  output logic     char_done,
  output rx_item_t char_item
);
  localparam int unsigned CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  rx_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    bit_q, bit_d;
  logic [7:0]    shf_q, shf_d;
  logic          par_q, par_d;
  logic          fe_q, fe_d;
  logic          pe_q, pe_d;
  logic          done_d;
  logic [2:0]    last_bit;
  logic          total;

  assign last_bit = cfg_7bit ? 3'd6 : 3'd7;
  assign total    = par_q ^ rx;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    shf_d   = shf_q;
    par_d   = par_q;
    fe_d    = fe_q;
    pe_d    = pe_q;
    done_d  = 1'b0;
    if (tick) begin
      case (state_q)
        ST_IDLE: begin
          if (!rx && !hold) begin
            state_d = ST_START;
            cnt_d   = '0;
          end
        end
        ST_START: begin
          if (cnt_q == MID) begin
            cnt_d = '0;
            if (rx) begin
              state_d = ST_IDLE;
            end else begin
              state_d = ST_DATA;
              bit_d   = '0;
              par_d   = 1'b0;
              fe_d    = 1'b0;
              pe_d    = 1'b0;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt_q == LAST) begin
            cnt_d = '0;
            shf_d = {rx, shf_q[7:1]};
            par_d = par_q ^ rx;
            if (bit_q == last_bit) begin
              state_d = cfg_par_en ? ST_PAR : ST_STOP1;
            end else begin
              bit_d = bit_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_PAR: begin
          if (cnt_q == LAST) begin
            cnt_d   = '0;
            pe_d    = cfg_par_odd ? ~total : total;
            state_d = ST_STOP1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_STOP1: begin
          if (cnt_q == LAST) begin
            cnt_d = '0;
            fe_d  = !rx;
            if (cfg_stop2) begin
              state_d = ST_STOP2;
            end else begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_STOP2: begin
          if (cnt_q == LAST) begin
            cnt_d   = '0;
            fe_d    = fe_q | !rx;
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shf_q   <= '0;
      par_q   <= 1'b0;
      fe_q    <= 1'b0;
      pe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      shf_q   <= shf_d;
      par_q   <= par_d;
      fe_q    <= fe_d;
      pe_q    <= pe_d;
    end
  end

  assign char_done      = done_d;
  assign char_item.data = cfg_7bit ? {1'b0, shf_q[7:1]} : shf_q;
  assign char_item.fe   = fe_d;
  assign char_item.pe   = pe_d;

  // R2: a high line at the mid-start sample abandons the character
  a_r2_glitch_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && tick && cnt_q == MID && rx) |=> state_q == ST_IDLE);
  // R10: no start while the break hold is active
  a_r10_no_start_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && hold) |=> state_q == ST_IDLE);
  // R5: a character completes only on an oversampling tick
  a_r5_done_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |-> tick);
endmodule

// File: rtl/serrx_fifo.sv
module serrx_fifo #(
  parameter int unsigned W     = 10,
  parameter int unsigned DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned NW = $clog2(DEPTH + 1);
  localparam logic [NW-1:0] DEPTH_N = NW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [NW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok, empty;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == DEPTH_N);
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push_ok) wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (pop_ok)  rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    if (push_ok && !pop_ok)      cnt_d = cnt_q + 1'b1;
    else if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wptr_q] <= wdata;
  end

  assign rdata = mem_q[rptr_q];
  assign count = cnt_q;

  // R7: the count never exceeds the depth
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DEPTH_N);
  // R8: a push into a full queue without a pop leaves it full
  a_r8_full_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (cnt_q == DEPTH_N && $stable(wptr_q)));
  // R6: a pop on an empty queue changes nothing
  a_r6_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> (cnt_q == '0 && $stable(rptr_q)));
endmodule

// File: rtl/serrx_brk.sv
module serrx_brk #(
  parameter int unsigned FTW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           rx,
  input  logic           char_done,
  input  logic           char_fe,
  input  logic [FTW-1:0] frame_ticks,
  input  logic           clr,
  output logic           hold,
  output logic           brk
);
  logic           hold_q, hold_d;
  logic           brk_q, brk_d;
  logic [FTW-1:0] cnt_q, cnt_d;
  logic           low_tick;

  assign low_tick = hold_q && tick && !rx;

  always_comb begin
    hold_d = hold_q;
    cnt_d  = cnt_q;
    brk_d  = brk_q && !clr;
    if (char_done && char_fe && !rx) begin
      hold_d = 1'b1;
      cnt_d  = '0;
    end else if (hold_q && rx) begin
      hold_d = 1'b0;
      cnt_d  = '0;
    end else if (low_tick && cnt_q <= frame_ticks) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == frame_ticks) brk_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      brk_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      hold_q <= hold_d;
      brk_q  <= brk_d;
      cnt_q  <= cnt_d;
    end
  end

  assign hold = hold_q;
  assign brk  = brk_q;

  // R9: the break flag rises only while a framing-error low is held
  a_r9_brk_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_q) |-> $past(hold_q));
  // R9: the break flag is sticky until cleared
  a_r9_brk_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_q && !clr) |=> brk_q);
endmodule

// File: rtl/serrx_top.sv
module serrx_top
  import serrx_pkg::*;
#(
  parameter int unsigned OVS   = 16,
  parameter int unsigned DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick16,
  input  logic                       rxd,
  input  logic                       cfg_7bit,
  input  logic                       cfg_par_en,
  input  logic                       cfg_par_odd,
  input  logic                       cfg_stop2,
  input  logic                       pop,
  input  logic                       clr_ovr,
  input  logic                       clr_brk,
  output logic [7:0]                 rd_data,
  output logic                       rd_fe,
  output logic                       rd_pe,
  output logic                       rd_valid,
  output logic [$clog2(DEPTH+1)-1:0] fill_cnt,
  output logic                       ovr_flag,
  output logic                       brk_flag
);
  localparam int unsigned MAX_BITS = 12;
  localparam int unsigned FTW      = $clog2(MAX_BITS * OVS + 2);
  localparam int unsigned NW       = $clog2(DEPTH + 1);

  logic           sync1_q, sync2_q;
  logic           char_done, hold, full;
  logic           ovr_q, ovr_d;
  rx_item_t       char_item, head;
  logic [3:0]     frame_bits;
  logic [FTW-1:0] frame_ticks;
  logic [NW-1:0]  count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= rxd;
      sync2_q <= sync1_q;
    end
  end

  assign frame_bits  = 4'd1 + (cfg_7bit ? 4'd7 : 4'd8) + {3'd0, cfg_par_en} + (cfg_stop2 ? 4'd2 : 4'd1);
  assign frame_ticks = FTW'(frame_bits * OVS);

  serrx_frame #(.OVS(OVS)) frame_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick16),
    .rx         (sync2_q),
    .cfg_7bit   (cfg_7bit),
    .cfg_par_en (cfg_par_en),
    .cfg_par_odd(cfg_par_odd),
    .cfg_stop2  (cfg_stop2),
    .hold       (hold),
    .char_done  (char_done),
    .char_item  (char_item)
  );

  serrx_fifo #(.W(ITEM_W), .DEPTH(DEPTH)) fifo_i (
    .clk  (clk),
    .rst_n(rst_n),
    .push (char_done),
    .wdata(char_item),
    .pop  (pop),
    .rdata(head),
    .count(count),
    .full (full)
  );

  serrx_brk #(.FTW(FTW)) brk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick16),
    .rx         (sync2_q),
    .char_done  (char_done),
    .char_fe    (char_item.fe),
    .frame_ticks(frame_ticks),
    .clr        (clr_brk),
    .hold       (hold),
    .brk        (brk_flag)
  );

  always_comb begin
    ovr_d = ovr_q && !clr_ovr;
    if (char_done && full && !pop) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  assign rd_data  = head.data;
  assign rd_fe    = head.fe;
  assign rd_pe    = head.pe;
  assign rd_valid = (count != '0);
  assign fill_cnt = count;
  assign ovr_flag = ovr_q;

  // R8: overrun is sticky until cleared
  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !clr_ovr) |=> ovr_q);
  // R10: no character completes while the break hold is active
  a_r10_no_char_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !char_done);
endmodule

// File: tb/serrx_top_tb_top.sv
module serrx_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic       c7 = 1'b0, cpe = 1'b0, codd = 1'b0, cs2 = 1'b0;
  logic       mon_pop = 1'b0, tb_pop = 1'b0;
  logic       clr_ovr = 1'b0, clr_brk = 1'b0;
  logic [7:0] rd_data;
  logic       rd_fe, rd_pe, rd_valid, ovr_flag, brk_flag;
  logic [4:0] fill_cnt;
  logic       pop;
  logic       mon_en = 1'b1;
  logic       ovr_seen = 1'b0;
  logic [1:0] tdiv = 2'd0;
  int         checks = 0;
  int         fails = 0;
  logic [9:0] exp_q[$];

  assign pop = mon_pop | tb_pop;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd3);
  end

  always @(posedge clk) if (ovr_flag) ovr_seen <= 1'b1;

  serrx_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .cfg_7bit(c7), .cfg_par_en(cpe), .cfg_par_odd(codd), .cfg_stop2(cs2),
    .pop(pop), .clr_ovr(clr_ovr), .clr_brk(clr_brk),
    .rd_data(rd_data), .rd_fe(rd_fe), .rd_pe(rd_pe), .rd_valid(rd_valid),
    .fill_cnt(fill_cnt), .ovr_flag(ovr_flag), .brk_flag(brk_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares each head entry and pops it
  always @(negedge clk) begin
    if (mon_en && rd_valid && !mon_pop) begin
      if (exp_q.size() == 0) begin
        chk("R6 unexpected entry", {rd_data, rd_fe, rd_pe}, 10'h3ff);
      end else begin
        chk("R3/R4/R5/R6 entry", {rd_data, rd_fe, rd_pe}, exp_q.pop_front());
      end
      mon_pop <= 1'b1;
    end else begin
      mon_pop <= 1'b0;
    end
  end

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!tick16);
    end
  endtask

  task automatic drive(input logic v);
    @(negedge clk) rxd = v;
    wait_ticks(16);
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par, input bit stop_low, input bit keep);
    logic [7:0] dm;
    int nb;
    nb = c7 ? 7 : 8;
    dm = c7 ? {1'b0, d[6:0]} : d;
    if (keep) exp_q.push_back({dm, stop_low, bad_par && cpe});
    drive(1'b0);
    for (int i = 0; i < nb; i++) drive(dm[i]);
    if (cpe) drive((^dm) ^ codd ^ bad_par);
    if (cs2) drive(1'b1);
    drive(!stop_low);
    drive(1'b1);
    drive(1'b1);
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    repeat (8) @(posedge clk);
  endtask

  task automatic run();
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 fill_cnt", fill_cnt, 0);
    chk("R1 ovr_flag", ovr_flag, 0);
    chk("R1 brk_flag", brk_flag, 0);
    // R6 pop on empty ignored
    mon_en = 1'b0;
    @(negedge clk) tb_pop = 1'b1;
    @(negedge clk) tb_pop = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 empty pop count", fill_cnt, 0);
    mon_en = 1'b1;
    // R3 8N1 patterns, LSB first
    send(8'h55, 0, 0, 1); send(8'hA3, 0, 0, 1); send(8'h00, 0, 0, 1); send(8'hFF, 0, 0, 1); send(8'h01, 0, 0, 1);
    drain();
    // R3 7-bit data, R4 even parity
    c7 = 1; cpe = 1; codd = 0;
    send(8'hC5, 0, 0, 1); send(8'h7F, 0, 0, 1); send(8'h12, 1, 0, 1);
    drain();
    // R4 odd parity with 8 bits, good and bad
    c7 = 0; codd = 1;
    send(8'h3C, 0, 0, 1); send(8'hB1, 1, 0, 1); send(8'h80, 0, 0, 1);
    drain();
    // R5 two stop bits, second stop low gives framing error
    cpe = 0; cs2 = 1;
    send(8'h96, 0, 0, 1); send(8'h69, 0, 1, 1); send(8'h0F, 0, 0, 1);
    drain();
    cs2 = 0;
    // R5 single stop low, short low: framing error but no break
    send(8'h42, 0, 1, 1);
    drain();
    chk("R9 short low no break", brk_flag, 0);
    // R2 glitch of 4 ticks is discarded
    @(negedge clk) rxd = 1'b0;
    wait_ticks(4);
    @(negedge clk) rxd = 1'b1;
    wait_ticks(40);
    chk("R2 glitch fill_cnt", fill_cnt, 0);
    chk("R2 glitch rd_valid", rd_valid, 0);
    // R7/R8 fill to depth, then overflow
    mon_en = 1'b0;
    for (int k = 0; k < 16; k++) send(8'(k * 13 + 1), 0, 0, 1);
    repeat (4) @(negedge clk);
    chk("R7 fill_cnt full", fill_cnt, 16);
    chk("R8 no overrun yet", ovr_flag, 0);
    ovr_seen = 1'b0;
    clr_ovr = 1'b1;
    send(8'hEE, 0, 0, 0);
    clr_ovr = 1'b0;
    chk("R8 overrun wins over held clear", ovr_seen, 1);
    send(8'hDD, 0, 0, 0);
    repeat (4) @(negedge clk);
    chk("R8 overrun sticky", ovr_flag, 1);
    chk("R8 dropped, fill_cnt", fill_cnt, 16);
    mon_en = 1'b1;
    drain();
    chk("R7 fill_cnt drained", fill_cnt, 0);
    @(negedge clk) clr_ovr = 1'b1;
    @(negedge clk) clr_ovr = 1'b0;
    @(negedge clk);
    chk("R8 overrun cleared", ovr_flag, 0);
    // R9/R10 long low: one framing-error entry, then break
    @(negedge clk) rxd = 1'b0;
    exp_q.push_back({8'h00, 1'b1, 1'b0});
    wait_ticks(3 * 160);
    chk("R9 break set", brk_flag, 1);
    chk("R10 single entry during low", exp_q.size(), 0);
    @(negedge clk) rxd = 1'b1;
    wait_ticks(40);
    chk("R9 break sticky after line high", brk_flag, 1);
    @(negedge clk) clr_brk = 1'b1;
    @(negedge clk) clr_brk = 1'b0;
    @(negedge clk);
    chk("R9 break cleared", brk_flag, 0);
    // R10 reception resumes once the line is high
    send(8'h5A, 0, 0, 1);
    drain();
    chk("R10 resume empty", fill_cnt, 0);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule